// File: doc/BRIEF.md
# ADC Auto-Trigger Controller with Locked Result Readout

This block is the digital control around an on-chip analog-to-digital converter. A 4-bit select code, held in a small trigger configuration register, chooses which peripheral event starts a conversion when auto-trigger mode is on. Software can also request a conversion directly at any time. The block watches the chosen event and issues a one-cycle start pulse to the converter. It then tracks the conversion until the converter's done strobe arrives.

The 10-bit conversion result is captured into a low byte and a high byte. Software reads the low byte first. From that read until the high byte is read, both bytes are frozen, so the two halves always belong to the same conversion.

Two state machines do the work. The conversion sequencer has three states: `CV_IDLE`, `CV_LAUNCH` and `CV_BUSY`. It moves from IDLE to LAUNCH on a start request. It moves from LAUNCH to BUSY if no done strobe arrives, or from LAUNCH back to IDLE if one does. It returns from BUSY to IDLE on the done strobe. The result latch has two states, `RL_OPEN` and `RL_HELD`. It moves from OPEN to HELD on a low-byte read and from HELD back to OPEN on a high-byte read.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `conv_start` and `conv_busy` are 0, both result bytes are 0 and `cfg_rdata` is 0.
- R2: A `sw_start` pulse while idle makes `conv_start` high in the next cycle, and `conv_busy` stays high until the cycle after `conv_done`.
- R3: With `auto_en` low, no event input starts a conversion. The same holds for a done strobe while the select code is 0.
- R4: With `auto_en` high, a rising edge on the selected flag raises `conv_start` in the next cycle. The select codes map as follows: codes 1 to 6 select `evt_flag[0]` to `evt_flag[5]`, and codes 10 to 13 select `cmp_out[0]` to `cmp_out[3]`. A flag that stays high does not start a second conversion.
- R5: Codes 7 to 9 select `sync_pulse[0]` to `sync_pulse[2]`. These sources have no flag. Each pulse seen while idle starts a conversion, and a pulse that arrives during a conversion is lost.
- R6: Code 0 means free-running. With `auto_en` high, `conv_start` rises in the second cycle after each `conv_done` strobe.
- R7: Codes 14 and 15 never produce a start, whatever the event inputs do.
- R8: Writing a new select code does not by itself start a conversion, even if the newly selected flag is already high.
- R9: Every start request, from software or from an event, is ignored while a conversion is busy. It is not remembered for later.
- R10: On `conv_done` while the result is unlocked, `res_lo` shows `conv_data[7:0]` and `res_hi` shows `conv_data[9:8]` in bits 1:0 (upper bits 0) from the next cycle.
- R11: After a `rd_lo` strobe, results that complete are discarded and both bytes hold until a `rd_hi` strobe. After that, the next result is captured again.
- R12: `cfg_rdata[4]` is reserved and always reads 0. `cfg_rdata[3:0]` returns the last written select code.
- R13: `conv_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the trigger configuration register |
| cfg_wdata | input | 5 | Write data: bits 3:0 are the select code, bit 4 is reserved |
| cfg_rdata | output | 5 | Configuration register read value |
| auto_en | input | 1 | Auto-trigger enable |
| sw_start | input | 1 | Software conversion request |
| evt_flag | input | 6 | Interrupt-flag style event sources |
| sync_pulse | input | 3 | Flagless PWM synchronisation pulses |
| cmp_out | input | 4 | Analog comparator outputs |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| conv_start | output | 1 | One-cycle start-of-conversion pulse |
| conv_busy | output | 1 | Conversion in progress |
| rd_lo | input | 1 | Low result byte read strobe |
| rd_hi | input | 1 | High result byte read strobe |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 8 | Result bits 9:8 in bits 1:0, upper bits 0 |

## Verification
A sequencer stuck outside IDLE shows at the ports at once, as a `conv_busy` that never drops after a done strobe. Every later trigger is then silently lost, and the next expected start pulse fails to appear one cycle after its event. A wrong edge-detect history or source mapping shows up as a missing or extra start pulse exactly one cycle after the event edge. A result latch stuck in HELD shows up at the next conversion as stale result bytes. A latch that is wrongly OPEN shows up as bytes that change between the low and high reads.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SEL_W   = 4;
    localparam int CFG_W   = SEL_W + 1;
    localparam int N_CODES = 1 << SEL_W;

    typedef enum logic [1:0] {
        CV_IDLE   = 2'd0,
        CV_LAUNCH = 2'd1,
        CV_BUSY   = 2'd2
    } conv_state_t;

    typedef enum logic {
        RL_OPEN = 1'b0,
        RL_HELD = 1'b1
    } latch_state_t;

endpackage

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
#(
    parameter int N_FLAG = 6,
    parameter int N_SYNC = 3,
    parameter int N_CMP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_FLAG-1:0] evt_flag,
    input  logic [N_SYNC-1:0] sync_pulse,
    input  logic [N_CMP-1:0]  cmp_out,
    input  logic              conv_done,
    output logic              trig
);

    localparam int N_LVL     = N_FLAG + N_CMP;
    localparam int SYNC_BASE = 1 + N_FLAG;
    localparam int CMP_BASE  = SYNC_BASE + N_SYNC;
    localparam int LAST_CODE = CMP_BASE + N_CMP - 1;

    logic [N_LVL-1:0]   lvl;
    logic [N_LVL-1:0]   lvl_q;
    logic [N_LVL-1:0]   rise;
    logic               done_q;
    logic [N_CODES-1:0] code_hit;

    // Each flag source keeps its own history, so retargeting the
    // select code never creates an edge.
    assign lvl  = {cmp_out, evt_flag};
    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            done_q <= 1'b0;
        end else begin
            lvl_q  <= lvl;
            done_q <= conv_done;
        end
    end

    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        if (c == 0) begin : g_free
            assign code_hit[c] = done_q;
        end else if (c < SYNC_BASE) begin : g_flag
            assign code_hit[c] = rise[c-1];
        end else if (c < CMP_BASE) begin : g_sync
            assign code_hit[c] = sync_pulse[c-SYNC_BASE];
        end else if (c <= LAST_CODE) begin : g_cmp
            assign code_hit[c] = rise[N_FLAG + c - CMP_BASE];
        end else begin : g_rsvd
            assign code_hit[c] = 1'b0;
        end
    end

    assign trig = code_hit[sel];

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic auto_en,
    input  logic trig,
    input  logic conv_done,
    output logic conv_start,
    output logic busy
);

    conv_state_t state_q;
    conv_state_t state_d;
    logic        req;

    assign req = sw_start | (auto_en & trig);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE:   if (req) state_d = CV_LAUNCH;
            CV_LAUNCH: state_d = conv_done ? CV_IDLE : CV_BUSY;
            CV_BUSY:   if (conv_done) state_d = CV_IDLE;
            default:   state_d = CV_IDLE;
        endcase
    end

    always_comb begin
        conv_start = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            CV_IDLE:   busy = 1'b0;
            CV_LAUNCH: conv_start = 1'b1;
            CV_BUSY:   conv_start = 1'b0;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
    import adc_trig_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [7:0]       res_lo,
    output logic [7:0]       res_hi,
    output logic             locked
);

    localparam int HI_W = RES_W - 8;

    latch_state_t     state_q;
    latch_state_t     state_d;
    logic [RES_W-1:0] data_q;
    logic             capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RL_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RL_OPEN: if (rd_lo) state_d = RL_HELD;
            RL_HELD: if (rd_hi) state_d = RL_OPEN;
            default: state_d = RL_OPEN;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        locked  = 1'b0;
        unique case (state_q)
            RL_OPEN: capture = conv_done & ~rd_lo;
            RL_HELD: locked  = 1'b1;
            default: capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= conv_data;
    end

    assign res_lo = data_q[7:0];
    assign res_hi = {{(8-HI_W){1'b0}}, data_q[RES_W-1:8]};

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int N_FLAG = 6,
    parameter int N_SYNC = 3,
    parameter int N_CMP  = 4,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              auto_en,
    input  logic              sw_start,
    input  logic [N_FLAG-1:0] evt_flag,
    input  logic [N_SYNC-1:0] sync_pulse,
    input  logic [N_CMP-1:0]  cmp_out,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              conv_start,
    output logic              conv_busy,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [7:0]        res_lo,
    output logic [7:0]        res_hi
);

    logic [SEL_W-1:0] sel_q;
    logic             trig;
    logic             res_locked;
    logic             cfg_rsvd_unused;

    // Reserved configuration bit: never stored, reads back as zero.
    assign cfg_rsvd_unused = cfg_wdata[CFG_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (cfg_wr) sel_q <= cfg_wdata[SEL_W-1:0];
    end

    assign cfg_rdata = {1'b0, sel_q};

    adc_trig_select #(
        .N_FLAG (N_FLAG),
        .N_SYNC (N_SYNC),
        .N_CMP  (N_CMP)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_q),
        .evt_flag   (evt_flag),
        .sync_pulse (sync_pulse),
        .cmp_out    (cmp_out),
        .conv_done  (conv_done),
        .trig       (trig)
    );

    adc_conv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_start   (sw_start),
        .auto_en    (auto_en),
        .trig       (trig),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .busy       (conv_busy)
    );

    adc_result_latch #(
        .RES_W (RES_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .res_lo    (res_lo),
        .res_hi    (res_hi),
        .locked    (res_locked)
    );

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cfg_rdata,
    input logic       auto_en,
    input logic       sw_start,
    input logic       conv_done,
    input logic [9:0] conv_data,
    input logic       conv_start,
    input logic       conv_busy,
    input logic       rd_lo,
    input logic [7:0] res_lo,
    input logic [7:0] res_hi,
    input logic       locked
);

    // R13: start pulse is exactly one cycle wide
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2: a start pulse always coincides with the busy indication
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy);

    // R9: a start pulse only follows an idle cycle
    a_r9_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(!conv_busy));

    // R3: without software request, a start needs auto mode
    a_r3_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(sw_start) || $past(auto_en)));

    // R7: reserved codes never launch
    a_r7_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(sw_start) || $past(cfg_rdata[3:1] != 3'b111)));

    // R10: unlocked completion is captured
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !locked && !rd_lo) |=>
            (res_lo == $past(conv_data[7:0]) && res_hi[1:0] == $past(conv_data[9:8])));

    // R11: locked bytes do not move
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(res_lo) && $stable(res_hi)));

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .auto_en    (auto_en),
    .sw_start   (sw_start),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .rd_lo      (rd_lo),
    .res_lo     (res_lo),
    .res_hi     (res_hi),
    .locked     (res_locked)
);

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       auto_en = 1'b0;
    logic       sw_start = 1'b0;
    logic [5:0] evt_flag = '0;
    logic [2:0] sync_pulse = '0;
    logic [3:0] cmp_out = '0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       conv_start;
    logic       conv_busy;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] res_lo;
    logic [7:0] res_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    adc_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .auto_en(auto_en), .sw_start(sw_start),
        .evt_flag(evt_flag), .sync_pulse(sync_pulse), .cmp_out(cmp_out),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_busy(conv_busy), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    // {code, data, start expected}
    localparam logic [14:0] VEC [15] = '{
        {4'd1,  10'h3A5, 1'b1}, {4'd2,  10'h15A, 1'b1}, {4'd3,  10'h2C3, 1'b1},
        {4'd4,  10'h0FF, 1'b1}, {4'd5,  10'h300, 1'b1}, {4'd6,  10'h1E1, 1'b1},
        {4'd7,  10'h27B, 1'b1}, {4'd8,  10'h044, 1'b1}, {4'd9,  10'h3FF, 1'b1},
        {4'd10, 10'h101, 1'b1}, {4'd11, 10'h2AA, 1'b1}, {4'd12, 10'h055, 1'b1},
        {4'd13, 10'h3C0, 1'b1}, {4'd14, 10'h111, 1'b0}, {4'd15, 10'h222, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_sel(input logic [4:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic drive_src(input logic [3:0] code, input logic val);
        if (!val) begin
            evt_flag = '0; sync_pulse = '0; cmp_out = '0;
        end else if (code >= 1 && code <= 6)   evt_flag[code-1] = 1'b1;
        else if (code >= 7 && code <= 9)       sync_pulse[code-7] = 1'b1;
        else if (code >= 10 && code <= 13)     cmp_out[code-10] = 1'b1;
        else begin
            evt_flag = '1; sync_pulse = '1; cmp_out = '1;
        end
    endtask

    task automatic finish_conv(input logic [9:0] d);
        conv_done = 1'b1; conv_data = d;
        step();
        conv_done = 1'b0;
    endtask

    task automatic read_both();
        rd_lo = 1'b1; step(); rd_lo = 1'b0;
        rd_hi = 1'b1; step(); rd_hi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 start", conv_start, 0);
        chk("R1 busy", conv_busy, 0);
        chk("R1 res_lo", res_lo, 0);
        chk("R1 res_hi", res_hi, 0);
        chk("R1 cfg", cfg_rdata, 0);
        rst_n = 1'b1;
        step();

        // R12 reserved bit
        write_sel(5'b11111);
        chk("R12 readback", cfg_rdata, 5'b01111);

        // R3 auto disabled: flag edge ignored
        write_sel(5'd1);
        evt_flag[0] = 1'b1; step();
        chk("R3 no auto start", conv_start, 0);
        step();
        chk("R3 still idle", conv_busy, 0);
        drive_src(0, 0); step();

        // R2 software start
        sw_start = 1'b1; step(); sw_start = 1'b0;
        chk("R2 start", conv_start, 1);
        chk("R2 busy", conv_busy, 1);
        step();
        chk("R13 one cycle", conv_start, 0);
        chk("R2 busy held", conv_busy, 1);
        finish_conv(10'h000);
        chk("R2 busy cleared", conv_busy, 0);
        read_both();

        // Table walk: R4 flags, R5 syncs, R7 reserved, R10 capture
        auto_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            logic [3:0] code;
            logic [9:0] d;
            logic       e;
            {code, d, e} = VEC[i];
            write_sel({1'b0, code});
            drive_src(code, 1'b1);
            step();
            chk(e ? "R4/R5 start on event" : "R7 reserved quiet", conv_start, e);
            drive_src(code, 1'b0);
            step();
            chk("R13 pulse width", conv_start, 0);
            if (e) begin
                chk("R2 busy during conv", conv_busy, 1);
                finish_conv(d);
                chk("R10 res_lo", res_lo, d[7:0]);
                chk("R10 res_hi", res_hi, {6'b0, d[9:8]});
                read_both();
            end else begin
                chk("R7 idle", conv_busy, 0);
            end
        end

        // R4 steady-high flag does not retrigger
        write_sel(5'd10);
        cmp_out[0] = 1'b1; step();
        chk("R4 edge start", conv_start, 1);
        finish_conv(10'h001);
        repeat (2) step();
        chk("R4 no retrigger while high", conv_start, 0);
        drive_src(0, 0); step();
        read_both();

        // R8 select change onto a high flag
        write_sel(5'd1);
        evt_flag[1] = 1'b1; step(); step();
        write_sel(5'd2);
        chk("R8 no start on retarget", conv_start, 0);
        step();
        chk("R8 still idle", conv_busy, 0);
        drive_src(0, 0); step();

        // R5 and R9: sync pulse during busy is lost
        write_sel(5'd7);
        sw_start = 1'b1; step(); sw_start = 1'b0;
        step();
        sync_pulse[0] = 1'b1; step(); sync_pulse[0] = 1'b0;
        step();
        chk("R5 busy kept", conv_busy, 1);
        finish_conv(10'h002);
        step();
        chk("R5 lost pulse", conv_start, 0);
        chk("R9 idle after lost", conv_busy, 0);
        // R9 flag edge during busy is not remembered
        write_sel(5'd1);
        sw_start = 1'b1; step(); sw_start = 1'b0;
        evt_flag[0] = 1'b1; step();
        sw_start = 1'b1; step(); sw_start = 1'b0;
        finish_conv(10'h003);
        step();
        chk("R9 no late start", conv_start, 0);
        drive_src(0, 0); step();
        read_both();

        // R6 free-running
        write_sel(5'd0);
        sw_start = 1'b1; step(); sw_start = 1'b0;
        chk("R6 first start", conv_start, 1);
        step();
        finish_conv(10'h004);
        chk("R6 not yet", conv_start, 0);
        step();
        chk("R6 retrigger", conv_start, 1);
        auto_en = 1'b0;
        step();
        finish_conv(10'h005);
        step();
        chk("R3 free-run off", conv_start, 0);
        step();
        chk("R3 idle", conv_busy, 0);
        read_both();

        // R11 lock sequence
        finish_conv(10'h2B7);
        chk("R10 A lo", res_lo, 8'hB7);
        rd_lo = 1'b1; step(); rd_lo = 1'b0;
        finish_conv(10'h148);
        chk("R11 held lo", res_lo, 8'hB7);
        chk("R11 held hi", res_hi, 8'h02);
        rd_hi = 1'b1; step(); rd_hi = 1'b0;
        chk("R11 still A after unlock", res_lo, 8'hB7);
        finish_conv(10'h3C9);
        chk("R11 new lo", res_lo, 8'hC9);
        chk("R11 new hi", res_hi, 8'h03);

        finish_run();
    end

endmodule